// File: doc/BRIEF.md
# Shared-Window Packet Channel Sequencer

This block is the management-controller side of a packet channel in which the bytes of each packet sit in a memory window that both the host and the controller can reach. The two sides coordinate through a small mailbox. The host writes one-byte commands that this block receives as events. This block writes a status byte and one-byte commands into the mailbox's output register, which interrupts the host. The block does not move packet bytes and does not check headers. It only decides who owns each area of the window and when the host must be told.

A write to the status register raises no interrupt on the host side. For that reason, every status update is followed by a filler byte 0xFF in the output register. Each packet area is handed across explicitly: a "transmit begin" command (0x01) gives an area to the receiver, and a "receive complete" command (0x02) gives it back. The host opens the channel with an "initialise" command (0x00). The block then agrees a protocol version with the host and derives the transfer size that both sides must use.

Top module: `pktChanSeq`

## Requirements
- R1: After reset no mailbox write is issued, `negVer`, `xferSize`, `errCount` and `channelUp` are 0, `txAreaFree` is 1 and `rxAreaHeld` is 0.
- R2: A `ctrlReady` pulse causes a status write of 0x80 (bit 7 = controller active), followed by a write of 0xFF to the output register. A status write never occurs in the same cycle as an output-register write.
- R3: An output-register write is issued only while `obfFull` is low. A byte that is due while the buffer is full is held until the host drains it. The mailbox raises `obfFull` in the cycle after a write.
- R4: An initialise command (0x00) received while the controller is active sets `negVer` to the smaller of the local and host current versions. That value is valid if it is nonzero and at least both minima. A valid result raises `channelUp`. If the channel was down, the block publishes status 0xC0 (bit 6 = channel active) followed by 0xFF.
- R5: An initialise that yields no valid version sets `negVer` to 0 and clears `channelUp`. If the channel had been up, the block publishes status 0x80 followed by 0xFF.
- R6: An initialise received before the controller is active is ignored. No write is issued, `negVer` stays 0 and `errCount` does not change.
- R7: `xferSize` is the baseline unit (64) when the negotiated version is 1, whatever `hostRxSize` says. For higher versions it is the larger of `hostRxSize` and 64. It is 0 when no version is valid.
- R8: A `txPktReady` pulse while the channel is up and `txAreaFree` is high writes 0x01 and lowers `txAreaFree`. While `txAreaFree` is low, the pulse is ignored.
- R9: A host 0x02 received while the channel is up raises `txAreaFree` again.
- R10: A host 0x01 received while the channel is up raises `rxAreaHeld`. A later `rxDone` pulse lowers it and writes 0x02.
- R11: Host commands 0x01 and 0x02 received while the channel is down are discarded, and each one adds 1 to `errCount`.
- R12: When both 0x02 and 0x01 are waiting for the output buffer, 0x02 is written first.
- R13: An accepted initialise returns both areas to their idle owners (`txAreaFree` 1, `rxAreaHeld` 0) and drops any command still waiting to be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| ctrlReady | input | 1 | Pulse: control area prepared, announce controller active |
| hostCmdValid | input | 1 | A host command byte has arrived |
| hostCmdByte | input | 8 | Host command value |
| hostVerMin | input | 16 | Host minimum protocol version |
| hostVerCur | input | 16 | Host current protocol version |
| hostRxSize | input | 16 | Transfer size proposed by the host |
| obfFull | input | 1 | Mailbox output buffer still holds an unread byte |
| statusWrEn | output | 1 | Write strobe for the mailbox status byte |
| statusWrData | output | 8 | Status byte value |
| odrWrEn | output | 1 | Write strobe for the mailbox output byte |
| odrWrData | output | 8 | Output byte value |
| txAreaFree | output | 1 | Local side owns its outbound area |
| txPktReady | input | 1 | Pulse: outbound packet written into the area |
| rxAreaHeld | output | 1 | Local side owns the inbound area |
| rxDone | input | 1 | Pulse: local consumer finished with the inbound packet |
| channelUp | output | 1 | Channel active with a valid version |
| negVer | output | 16 | Negotiated version, 0 when none |
| xferSize | output | 16 | Transfer size in bytes for the negotiated version |
| errCount | output | 8 | Count of transfer commands received out of state |

## Verification
The bench keeps the output buffer full while status changes and commands become due. A design that ignored `obfFull` would overwrite an unread byte. A design that wrote the status byte and the filler together, or skipped the filler, would leave the host without an interrupt. It queues a "receive complete" and a "transmit begin" behind a full buffer to expose a wrong ordering. It feeds a version-1 host a large proposed size to catch a design that trusts the advertised size. It also sends an initialise that cannot be satisfied, which catches a design that leaves the channel up or reports a stale version. Transfer commands sent before the channel opens must leave ownership unchanged and raise the error count. A design that accepted them would hand out an area too early.

// File: rtl/pktChanSeqPkg.sv
package pktChanSeqPkg;

  localparam logic [7:0] CMD_INIT   = 8'h00;
  localparam logic [7:0] CMD_TX_BEG = 8'h01;
  localparam logic [7:0] CMD_RX_CMP = 8'h02;
  localparam logic [7:0] CMD_DUMMY  = 8'hFF;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic setActive;
    logic setChan;
    logic clrChan;
    logic loadVer;
    logic wrStatus;
    logic wrDummy;
    logic wrRxCmp;
    logic wrTxBeg;
    logic incErr;
  } dpStrobe_t;

  typedef enum logic {
    PUB_IDLE,
    PUB_DUMMY
  } pubState_t;

endpackage

// File: rtl/pktChanSeqData.sv
module pktChanSeqData
  import pktChanSeqPkg::*;
#(
  parameter int VER_W       = 16,
  parameter int SIZE_W      = 16,
  parameter int ERR_W       = 8,
  parameter int LOC_VER_MIN = 1,
  parameter int LOC_VER_CUR = 2,
  parameter int BTU_SIZE    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [VER_W-1:0]  hostVerMin,
  input  logic [VER_W-1:0]  hostVerCur,
  input  logic [SIZE_W-1:0] hostRxSize,
  output logic              bmcActive,
  output logic              chanActive,
  output logic              verOk,
  output logic              statusWrEn,
  output logic [7:0]        statusWrData,
  output logic              odrWrEn,
  output logic [7:0]        odrWrData,
  output logic [VER_W-1:0]  negVer,
  output logic [SIZE_W-1:0] xferSize,
  output logic [ERR_W-1:0]  errCount
);

  localparam logic [VER_W-1:0]  LocMin  = VER_W'(LOC_VER_MIN);
  localparam logic [VER_W-1:0]  LocCur  = VER_W'(LOC_VER_CUR);
  localparam logic [VER_W-1:0]  VerOne  = VER_W'(1);
  localparam logic [SIZE_W-1:0] BtuSize = SIZE_W'(BTU_SIZE);
  localparam logic [ERR_W-1:0]  ErrMax  = '1;

  logic [VER_W-1:0]  verCand;
  logic [SIZE_W-1:0] sizeCand;

  // candidate version: lower of both current versions, checked against minima
  always_comb begin
    verCand = (LocCur < hostVerCur) ? LocCur : hostVerCur;
    verOk   = (verCand != '0) && (verCand >= LocMin) && (verCand >= hostVerMin);
    if (verCand == VerOne) begin
      sizeCand = BtuSize;
    end else begin
      sizeCand = (hostRxSize > BtuSize) ? hostRxSize : BtuSize;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bmcActive  <= 1'b0;
      chanActive <= 1'b0;
      negVer     <= '0;
      xferSize   <= '0;
      errCount   <= '0;
    end else begin
      if (stb.setActive) bmcActive <= 1'b1;
      if (stb.setChan) begin
        chanActive <= 1'b1;
      end else if (stb.clrChan) begin
        chanActive <= 1'b0;
      end
      if (stb.loadVer) begin
        negVer   <= verOk ? verCand : '0;
        xferSize <= verOk ? sizeCand : '0;
      end
      if (stb.incErr && (errCount != ErrMax)) errCount <= errCount + 1'b1;
    end
  end

  // mailbox write port
  always_comb begin
    statusWrEn   = stb.wrStatus;
    statusWrData = {bmcActive, chanActive, 6'b000000};
    odrWrEn      = stb.wrDummy | stb.wrRxCmp | stb.wrTxBeg;
    if (stb.wrRxCmp) begin
      odrWrData = CMD_RX_CMP;
    end else if (stb.wrTxBeg) begin
      odrWrData = CMD_TX_BEG;
    end else begin
      odrWrData = CMD_DUMMY;
    end
  end

endmodule

// File: rtl/pktChanSeqCtrl.sv
module pktChanSeqCtrl
  import pktChanSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlReady,
  input  logic       hostCmdValid,
  input  logic [7:0] hostCmdByte,
  input  logic       txPktReady,
  input  logic       rxDone,
  input  logic       obfFull,
  input  logic       bmcActive,
  input  logic       chanActive,
  input  logic       verOk,
  output dpStrobe_t  stb,
  output logic       txAreaFree,
  output logic       rxAreaHeld
);

  pubState_t pubState, pubStateNext;
  logic pendStatus, pendRx, pendTx;
  logic isInit, isTxBeg, isRxCmp, chanUp, statusChange;
  logic takeTx, releaseRx;

  assign isInit  = hostCmdValid && (hostCmdByte == CMD_INIT);
  assign isTxBeg = hostCmdValid && (hostCmdByte == CMD_TX_BEG);
  assign isRxCmp = hostCmdValid && (hostCmdByte == CMD_RX_CMP);
  assign chanUp  = bmcActive && chanActive;

  assign takeTx    = txPktReady && txAreaFree && chanUp;
  assign releaseRx = rxDone && rxAreaHeld;

  always_comb begin
    stb          = '0;
    pubStateNext = pubState;

    stb.setActive = ctrlReady && !bmcActive;
    if (isInit && bmcActive) begin
      stb.loadVer = 1'b1;
      stb.setChan = verOk;
      stb.clrChan = !verOk;
    end
    stb.incErr = (isTxBeg || isRxCmp) && !chanUp;

    statusChange = stb.setActive ||
                   (stb.setChan && !chanActive) ||
                   (stb.clrChan && chanActive);

    // publisher: status then filler; commands in priority order
    unique case (pubState)
      PUB_IDLE: begin
        if (pendStatus) begin
          stb.wrStatus = 1'b1;
          pubStateNext = PUB_DUMMY;
        end else if (!obfFull && pendRx) begin
          stb.wrRxCmp = 1'b1;
        end else if (!obfFull && pendTx) begin
          stb.wrTxBeg = 1'b1;
        end
      end
      PUB_DUMMY: begin
        if (!obfFull) begin
          stb.wrDummy  = 1'b1;
          pubStateNext = PUB_IDLE;
        end
      end
      default: pubStateNext = PUB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pubState   <= PUB_IDLE;
      pendStatus <= 1'b0;
      pendRx     <= 1'b0;
      pendTx     <= 1'b0;
      txAreaFree <= 1'b1;
      rxAreaHeld <= 1'b0;
    end else begin
      pubState   <= pubStateNext;
      pendStatus <= (pendStatus && !stb.wrStatus) || statusChange;

      if (stb.loadVer) begin
        txAreaFree <= 1'b1;
        pendTx     <= 1'b0;
      end else begin
        if (isRxCmp && chanUp) begin
          txAreaFree <= 1'b1;
        end else if (takeTx) begin
          txAreaFree <= 1'b0;
        end
        if (takeTx) begin
          pendTx <= 1'b1;
        end else if (stb.wrTxBeg) begin
          pendTx <= 1'b0;
        end
      end

      if (stb.loadVer) begin
        rxAreaHeld <= 1'b0;
        pendRx     <= 1'b0;
      end else begin
        if (isTxBeg && chanUp) begin
          rxAreaHeld <= 1'b1;
        end else if (releaseRx) begin
          rxAreaHeld <= 1'b0;
        end
        if (releaseRx) begin
          pendRx <= 1'b1;
        end else if (stb.wrRxCmp) begin
          pendRx <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pktChanSeq.sv
module pktChanSeq
  import pktChanSeqPkg::*;
#(
  parameter int VER_W       = 16,
  parameter int SIZE_W      = 16,
  parameter int ERR_W       = 8,
  parameter int LOC_VER_MIN = 1,
  parameter int LOC_VER_CUR = 2,
  parameter int BTU_SIZE    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlReady,
  input  logic              hostCmdValid,
  input  logic [7:0]        hostCmdByte,
  input  logic [VER_W-1:0]  hostVerMin,
  input  logic [VER_W-1:0]  hostVerCur,
  input  logic [SIZE_W-1:0] hostRxSize,
  input  logic              obfFull,
  output logic              statusWrEn,
  output logic [7:0]        statusWrData,
  output logic              odrWrEn,
  output logic [7:0]        odrWrData,
  output logic              txAreaFree,
  input  logic              txPktReady,
  output logic              rxAreaHeld,
  input  logic              rxDone,
  output logic              channelUp,
  output logic [VER_W-1:0]  negVer,
  output logic [SIZE_W-1:0] xferSize,
  output logic [ERR_W-1:0]  errCount
);

  dpStrobe_t stb;
  logic bmcActive, chanActive, verOk;

  pktChanSeqCtrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlReady    (ctrlReady),
    .hostCmdValid (hostCmdValid),
    .hostCmdByte  (hostCmdByte),
    .txPktReady   (txPktReady),
    .rxDone       (rxDone),
    .obfFull      (obfFull),
    .bmcActive    (bmcActive),
    .chanActive   (chanActive),
    .verOk        (verOk),
    .stb          (stb),
    .txAreaFree   (txAreaFree),
    .rxAreaHeld   (rxAreaHeld)
  );

  pktChanSeqData #(
    .VER_W       (VER_W),
    .SIZE_W      (SIZE_W),
    .ERR_W       (ERR_W),
    .LOC_VER_MIN (LOC_VER_MIN),
    .LOC_VER_CUR (LOC_VER_CUR),
    .BTU_SIZE    (BTU_SIZE)
  ) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .hostVerMin   (hostVerMin),
    .hostVerCur   (hostVerCur),
    .hostRxSize   (hostRxSize),
    .bmcActive    (bmcActive),
    .chanActive   (chanActive),
    .verOk        (verOk),
    .statusWrEn   (statusWrEn),
    .statusWrData (statusWrData),
    .odrWrEn      (odrWrEn),
    .odrWrData    (odrWrData),
    .negVer       (negVer),
    .xferSize     (xferSize),
    .errCount     (errCount)
  );

  assign channelUp = bmcActive && chanActive;

endmodule

// File: rtl/pktChanSeqChk.sv
module pktChanSeqChk #(
  parameter int VER_W = 16,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             obfFull,
  input logic             statusWrEn,
  input logic [7:0]       statusWrData,
  input logic             odrWrEn,
  input logic [7:0]       odrWrData,
  input logic             txAreaFree,
  input logic             rxAreaHeld,
  input logic             channelUp,
  input logic [VER_W-1:0] negVer,
  input logic [ERR_W-1:0] errCount
);

  assert_status_alone_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWrEn |-> !odrWrEn);

  assert_filler_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWrEn |=> (!odrWrEn || odrWrData == 8'hFF));

  assert_status_bit7_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWrEn |-> statusWrData[7] && (statusWrData[5:0] == 6'd0));

  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rstN)
    odrWrEn |-> !obfFull);

  assert_chan_has_ver_R4: assert property (@(posedge clk) disable iff (!rstN)
    channelUp |-> (negVer != '0));

  assert_txbeg_owner_R8: assert property (@(posedge clk) disable iff (!rstN)
    (odrWrEn && odrWrData == 8'h01) |-> !txAreaFree);

  assert_rxcmp_owner_R10: assert property (@(posedge clk) disable iff (!rstN)
    (odrWrEn && odrWrData == 8'h02) |-> !rxAreaHeld);

  assert_err_monotonic_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> errCount >= $past(errCount));

endmodule

bind pktChanSeq pktChanSeqChk #(.VER_W(VER_W), .ERR_W(ERR_W)) chk_i (.*);

// File: tb/pktChanSeq_tb_top.sv
`timescale 1ns/100ps
module pktChanSeq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlReady = 1'b0;
  logic        hostCmdValid = 1'b0;
  logic [7:0]  hostCmdByte = 8'h00;
  logic [15:0] hostVerMin = 16'd1;
  logic [15:0] hostVerCur = 16'd1;
  logic [15:0] hostRxSize = 16'd200;
  logic        obfFull;
  logic        statusWrEn, odrWrEn;
  logic [7:0]  statusWrData, odrWrData;
  logic        txAreaFree, txPktReady = 1'b0;
  logic        rxAreaHeld, rxDone = 1'b0;
  logic        channelUp;
  logic [15:0] negVer, xferSize;
  logic [7:0]  errCount;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic drainReq = 1'b0;

  // mailbox log: kind 0 = status, 1 = output byte
  logic       logKind [0:63];
  logic [7:0] logData [0:63];
  int logCount = 0;
  int rdPtr = 0;

  always #2.5 clk = ~clk;

  pktChanSeq dut_i (
    .clk (clk), .rstN (rstN), .ctrlReady (ctrlReady),
    .hostCmdValid (hostCmdValid), .hostCmdByte (hostCmdByte),
    .hostVerMin (hostVerMin), .hostVerCur (hostVerCur), .hostRxSize (hostRxSize),
    .obfFull (obfFull), .statusWrEn (statusWrEn), .statusWrData (statusWrData),
    .odrWrEn (odrWrEn), .odrWrData (odrWrData), .txAreaFree (txAreaFree),
    .txPktReady (txPktReady), .rxAreaHeld (rxAreaHeld), .rxDone (rxDone),
    .channelUp (channelUp), .negVer (negVer), .xferSize (xferSize),
    .errCount (errCount)
  );

  // mailbox model: output buffer fills on write, empties on host read
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obfFull <= 1'b0;
    end else begin
      if (odrWrEn) obfFull <= 1'b1;
      else if (drainReq) obfFull <= 1'b0;
      if (statusWrEn && logCount < 64) begin
        logKind[logCount] <= 1'b0;
        logData[logCount] <= statusWrData;
      end
      if (odrWrEn && logCount < 64) begin
        logKind[logCount] <= 1'b1;
        logData[logCount] <= odrWrData;
      end
      if ((statusWrEn || odrWrEn) && logCount < 64) logCount <= logCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic expectLog(input bit kind, input logic [7:0] data, input string req);
    checks++;
    if (rdPtr >= logCount) begin
      fails++;
      $display("FAIL %s: actual no write expected kind %0d data 0x%0h", req, kind, data);
    end else begin
      if (logKind[rdPtr] != kind || logData[rdPtr] != data) begin
        fails++;
        $display("FAIL %s: actual kind %0d data 0x%0h expected kind %0d data 0x%0h",
                 req, logKind[rdPtr], logData[rdPtr], kind, data);
      end
      rdPtr++;
    end
  endtask

  task automatic expectNoLog(input string req);
    check(logCount == rdPtr, req, logCount - rdPtr, 0);
    rdPtr = logCount;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hostCmd(input logic [7:0] b);
    @(negedge clk);
    hostCmdValid = 1'b1;
    hostCmdByte  = b;
    @(negedge clk);
    hostCmdValid = 1'b0;
    waitCycles(3);
  endtask

  task automatic pulseReady();
    @(negedge clk); txPktReady = 1'b1;
    @(negedge clk); txPktReady = 1'b0;
    waitCycles(3);
  endtask

  task automatic pulseDone();
    @(negedge clk); rxDone = 1'b1;
    @(negedge clk); rxDone = 1'b0;
    waitCycles(3);
  endtask

  task automatic drain();
    @(negedge clk); drainReq = 1'b1;
    @(negedge clk); drainReq = 1'b0;
    waitCycles(3);
  endtask

  task automatic testReset();
    waitCycles(2);
    check(channelUp == 1'b0, "R1 channelUp", channelUp, 0);
    check(negVer == 16'd0 && xferSize == 16'd0, "R1 version/size", negVer, 0);
    check(errCount == 8'd0, "R1 errCount", errCount, 0);
    check(txAreaFree == 1'b1 && rxAreaHeld == 1'b0, "R1 ownership", {txAreaFree, rxAreaHeld}, 2'b10);
    expectNoLog("R1 no writes");
  endtask

  task automatic testEarlyCmds();
    hostCmd(8'h01);
    hostCmd(8'h02);
    check(errCount == 8'd2, "R11 early commands counted", errCount, 2);
    check(rxAreaHeld == 1'b0 && txAreaFree == 1'b1, "R11 ownership unchanged", {txAreaFree, rxAreaHeld}, 2'b10);
    hostCmd(8'h00);
    check(negVer == 16'd0, "R6 init before active", negVer, 0);
    check(errCount == 8'd2, "R6 errCount unchanged", errCount, 2);
    expectNoLog("R6 R11 no writes");
  endtask

  task automatic testBringUp();
    @(negedge clk); ctrlReady = 1'b1;
    @(negedge clk); ctrlReady = 1'b0;
    waitCycles(5);
    expectLog(1'b0, 8'h80, "R2 status active");
    expectLog(1'b1, 8'hFF, "R2 filler");
    check(obfFull == 1'b1, "R3 buffer full after filler", obfFull, 1);
  endtask

  task automatic testInitV1Held();
    hostVerMin = 16'd1; hostVerCur = 16'd1; hostRxSize = 16'd200;
    hostCmd(8'h00);
    waitCycles(4);
    expectLog(1'b0, 8'hC0, "R4 status channel");
    expectNoLog("R3 filler held while full");
    check(channelUp == 1'b1, "R4 channelUp", channelUp, 1);
    check(negVer == 16'd1, "R4 negVer", negVer, 1);
    check(xferSize == 16'd64, "R7 v1 uses baseline", xferSize, 64);
    drain();
    expectLog(1'b1, 8'hFF, "R3 filler after drain");
    drain();
  endtask

  task automatic testTx();
    pulseReady();
    expectLog(1'b1, 8'h01, "R8 transmit begin");
    check(txAreaFree == 1'b0, "R8 area handed over", txAreaFree, 0);
    drain();
    pulseReady();
    expectNoLog("R8 second ready ignored");
    hostCmd(8'h02);
    check(txAreaFree == 1'b1, "R9 area returned", txAreaFree, 1);
  endtask

  task automatic testRx();
    hostCmd(8'h01);
    check(rxAreaHeld == 1'b1, "R10 inbound held", rxAreaHeld, 1);
    expectNoLog("R10 nothing written on take");
    pulseDone();
    expectLog(1'b1, 8'h02, "R10 receive complete");
    check(rxAreaHeld == 1'b0, "R10 inbound released", rxAreaHeld, 0);
    drain();
  endtask

  task automatic testPriority();
    pulseReady();
    expectLog(1'b1, 8'h01, "R12 first transmit begin");
    hostCmd(8'h02);
    hostCmd(8'h01);
    pulseReady();
    pulseDone();
    expectNoLog("R3 both held while full");
    drain();
    expectLog(1'b1, 8'h02, "R12 receive complete first");
    drain();
    expectLog(1'b1, 8'h01, "R12 transmit begin second");
    drain();
  endtask

  task automatic testReinit();
    hostCmd(8'h01);
    check(rxAreaHeld == 1'b1 && txAreaFree == 1'b0, "R13 setup ownership", {txAreaFree, rxAreaHeld}, 2'b01);
    hostVerMin = 16'd1; hostVerCur = 16'd3; hostRxSize = 16'd200;
    hostCmd(8'h00);
    check(negVer == 16'd2, "R4 negVer lower current", negVer, 2);
    check(xferSize == 16'd200, "R7 v2 uses proposed size", xferSize, 200);
    check(txAreaFree == 1'b1 && rxAreaHeld == 1'b0, "R13 ownership reset", {txAreaFree, rxAreaHeld}, 2'b10);
    expectNoLog("R4 no publish when already up");
    hostRxSize = 16'd20;
    hostCmd(8'h00);
    check(xferSize == 16'd64, "R7 small size raised to baseline", xferSize, 64);
  endtask

  task automatic testInvalid();
    hostVerMin = 16'd3; hostVerCur = 16'd5;
    hostCmd(8'h00);
    waitCycles(3);
    check(negVer == 16'd0 && xferSize == 16'd0, "R5 R7 invalid version", negVer, 0);
    check(channelUp == 1'b0, "R5 channel down", channelUp, 0);
    expectLog(1'b0, 8'h80, "R5 status drop");
    expectLog(1'b1, 8'hFF, "R5 filler");
    drain();
    hostCmd(8'h01);
    check(errCount == 8'd3, "R11 count after close", errCount, 3);
    check(rxAreaHeld == 1'b0, "R11 no take after close", rxAreaHeld, 0);
  endtask

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    testReset();
    testEarlyCmds();
    testBringUp();
    testInitV1Held();
    testTx();
    testRx();
    testPriority();
    testReinit();
    testInvalid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule